// File: doc/BRIEF.md
# Scheduled Square-Wave Pin and Edge Capture

This block owns one timing pin and works against a free-running 64-bit time counter supplied from outside. In output mode it is armed with an absolute start time and a half-period. Once armed, it holds the pin low until the counter reaches the start time. It then inverts the pin each time another half-period of ticks has passed, which gives a square wave with equal high and low times. The wave runs until a stop command arrives. A start command whose start time is not strictly in the future is dropped. The wave frequency is one second divided by twice the half-period times the tick length.

In capture mode the pin is an input. It passes through a two-flop synchronizer. Every change of the synchronized level, rising or falling, copies the current counter value into a single capture register. That register is the only store: a later edge overwrites it, and there is no flag, queue or interrupt. Software writes the start time and the half-period through a small write port and issues start and stop as one-cycle pulses.

Top module: `timepin_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, pin_out is 0 and cap_time is 0. With mode_capture at 0, pin_oe is 1.
- R2: A start pulse is dropped, and the pin stays low with no toggles, when the start-time register is not strictly greater than time_now in that cycle or when the half-period register is 0.
- R3: An accepted start arms the schedule and forces the pin low. The pin first goes high at the clock edge that ends the first cycle in which time_now is greater than or equal to the start time.
- R4: After the first edge, the pin inverts at the edge ending each cycle in which time_now reaches the previous compare time plus the half-period. The compare time is a full 64-bit value, so the pin is high and low for equal numbers of ticks, including across a carry out of the low 32 bits.
- R5: A stop pulse clears the schedule, and from the next clock edge the pin is low and does not toggle. Stop wins over a start pulse in the same cycle.
- R6: With mode_capture at 1 (capture mode), pin_oe is 0. pin_out goes to 0 at the next edge, the schedule is cleared, and start pulses are ignored. With mode_capture at 0, pin_oe is 1.
- R7: In capture mode, a change of pin_in that the first synchronizer flop samples at edge k loads cap_time at edge k+2 with the time_now value present between edges k+1 and k+2. This holds for both rising and falling changes.
- R8: cap_time holds one value only. A later edge overwrites it, and with no edge it keeps its value.
- R9: In output mode, changes of pin_in leave cap_time unchanged.
- R10: A start accepted while a wave is running restarts the schedule from the new start time, with the pin forced low at arming.
- R11: The write port decodes cfg_addr 0 as the 64-bit start time and cfg_addr 1 as the half-period. Only the low 32 bits of cfg_wdata are kept for the half-period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Current value of the time counter in ticks |
| mode_capture | input | 1 | 1 = pin is a capture input, 0 = pin drives the square wave |
| cfg_wr | input | 1 | Write strobe for the configuration registers |
| cfg_addr | input | 1 | 0 = start time, 1 = half-period |
| cfg_wdata | input | 64 | Write data |
| cmd_start | input | 1 | One-cycle pulse that arms the wave |
| cmd_stop | input | 1 | One-cycle pulse that halts the wave |
| pin_in | input | 1 | Pin level as seen from outside (asynchronous) |
| pin_out | output | 1 | Pin level driven in output mode |
| pin_oe | output | 1 | Pin output enable |
| cap_time | output | 64 | Time of the latest captured pin edge |

## Verification
A wrong compare value or a missed half-period add moves an edge of pin_out away from the tick that the start time and half-period predict. The bench compares the pin against a closed-form level every cycle, so the error shows at the first misplaced edge, within one half-period. A stuck schedule flag shows up as toggles after a stop or a mode switch, or as no toggles after a valid start. A fault in the synchronizer depth or in the edge detector shows in cap_time three edges after the pin changes, as a value that is one tick off, or as a value that did not change when it should have.

// File: rtl/timepin_pkg.sv
package timepin_pkg;

    localparam int TS_W_DEF   = 64;
    localparam int HP_W_DEF   = 32;
    localparam int SYNC_N_DEF = 2;

    typedef enum logic {
        CFG_START = 1'b0,
        CFG_HALF  = 1'b1
    } cfg_addr_e;

    // Next compare time: previous compare plus the zero-extended half-period
    function automatic logic [TS_W_DEF-1:0] advance_edge(
        input logic [TS_W_DEF-1:0] t,
        input logic [HP_W_DEF-1:0] h
    );
        return t + TS_W_DEF'(h);
    endfunction

endpackage

// File: rtl/timepin_cfg_regs.sv
module timepin_cfg_regs
    import timepin_pkg::*;
#(
    parameter int TS_W = TS_W_DEF,
    parameter int HP_W = HP_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  cfg_addr_e       wr_addr,
    input  logic [TS_W-1:0] wr_data,
    output logic [TS_W-1:0] start_time,
    output logic [HP_W-1:0] half_per
);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_time <= '0;
            half_per   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                CFG_START: start_time <= wr_data;
                CFG_HALF:  half_per   <= wr_data[HP_W-1:0];
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/timepin_wave_gen.sv
module timepin_wave_gen
    import timepin_pkg::*;
#(
    parameter int TS_W = TS_W_DEF,
    parameter int HP_W = HP_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            out_mode,
    input  logic            cmd_start,
    input  logic            cmd_stop,
    input  logic [TS_W-1:0] time_now,
    input  logic [TS_W-1:0] start_time,
    input  logic [HP_W-1:0] half_per,
    output logic            level,
    output logic            running
);

    typedef struct packed {
        logic            run;
        logic            lvl;
        logic [TS_W-1:0] due;
    } sched_t;

    sched_t st_q;
    logic   arm_ok;
    logic   due_hit;

    assign arm_ok  = out_mode && cmd_start && (start_time > time_now) && (half_per != '0);
    assign due_hit = st_q.run && (time_now >= st_q.due);

    always_ff @(posedge clk) begin
        if (rst || !out_mode || cmd_stop) begin
            st_q <= '0;
        end else if (arm_ok) begin
            st_q.run <= 1'b1;
            st_q.lvl <= 1'b0;
            st_q.due <= start_time;
        end else if (due_hit) begin
            st_q.lvl <= ~st_q.lvl;
            st_q.due <= st_q.due + TS_W'(half_per);
        end
    end

    assign level   = st_q.lvl;
    assign running = st_q.run;

endmodule

// File: rtl/timepin_edge_cap.sv
module timepin_edge_cap
    import timepin_pkg::*;
#(
    parameter int TS_W   = TS_W_DEF,
    parameter int SYNC_N = SYNC_N_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cap_mode,
    input  logic            pin_in,
    input  logic [TS_W-1:0] time_now,
    output logic [TS_W-1:0] cap_time
);

    logic [SYNC_N-1:0] sync_q;
    logic              hist_q;
    logic              edge_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], pin_in};
            hist_q <= sync_q[SYNC_N-1];
        end
    end

    assign edge_seen = sync_q[SYNC_N-1] ^ hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_time <= '0;
        end else if (cap_mode && edge_seen) begin
            cap_time <= time_now;
        end
    end

endmodule

// File: rtl/timepin_sched.sv
module timepin_sched
    import timepin_pkg::*;
#(
    parameter int TS_W   = TS_W_DEF,
    parameter int HP_W   = HP_W_DEF,
    parameter int SYNC_N = SYNC_N_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TS_W-1:0] time_now,
    input  logic            mode_capture,
    input  logic            cfg_wr,
    input  logic            cfg_addr,
    input  logic [TS_W-1:0] cfg_wdata,
    input  logic            cmd_start,
    input  logic            cmd_stop,
    input  logic            pin_in,
    output logic            pin_out,
    output logic            pin_oe,
    output logic [TS_W-1:0] cap_time
);

    logic [TS_W-1:0] start_time;
    logic [HP_W-1:0] half_per;
    logic            running;
    logic            wave_lvl;

    timepin_cfg_regs #(.TS_W(TS_W), .HP_W(HP_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_wr),
        .wr_addr    (cfg_addr_e'(cfg_addr)),
        .wr_data    (cfg_wdata),
        .start_time (start_time),
        .half_per   (half_per)
    );

    timepin_wave_gen #(.TS_W(TS_W), .HP_W(HP_W)) u_wave (
        .clk        (clk),
        .rst        (rst),
        .out_mode   (!mode_capture),
        .cmd_start  (cmd_start),
        .cmd_stop   (cmd_stop),
        .time_now   (time_now),
        .start_time (start_time),
        .half_per   (half_per),
        .level      (wave_lvl),
        .running    (running)
    );

    timepin_edge_cap #(.TS_W(TS_W), .SYNC_N(SYNC_N)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .cap_mode (mode_capture),
        .pin_in   (pin_in),
        .time_now (time_now),
        .cap_time (cap_time)
    );

    assign pin_out = wave_lvl;
    assign pin_oe  = !mode_capture;

endmodule

// File: rtl/timepin_sched_chk.sv
module timepin_sched_chk #(
    parameter int TS_W = 64,
    parameter int HP_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [TS_W-1:0] time_now,
    input logic            mode_capture,
    input logic            cmd_start,
    input logic            cmd_stop,
    input logic            pin_out,
    input logic [TS_W-1:0] cap_time,
    input logic            running,
    input logic [TS_W-1:0] start_time,
    input logic [HP_W-1:0] half_per
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!pin_out && cap_time == '0));

    p_late_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!mode_capture && cmd_start && !cmd_stop && !running && (start_time <= time_now))
        |=> !running);

    p_arm_low_r3: assert property (@(posedge clk) disable iff (rst)
        (!mode_capture && cmd_start && !cmd_stop && (start_time > time_now) && (half_per != '0))
        |=> (running && !pin_out));

    p_toggle_needs_run_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(pin_out)) |-> $past(running));

    p_stop_low_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_stop |=> (!running && !pin_out));

    p_capmode_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        mode_capture |=> (!running && !pin_out));

    p_cap_value_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(cap_time)) |-> (cap_time == $past(time_now)));

    p_cap_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !mode_capture |=> $stable(cap_time));

endmodule

bind timepin_sched timepin_sched_chk #(.TS_W(TS_W), .HP_W(HP_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .time_now     (time_now),
    .mode_capture (mode_capture),
    .cmd_start    (cmd_start),
    .cmd_stop     (cmd_stop),
    .pin_out      (pin_out),
    .cap_time     (cap_time),
    .running      (running),
    .start_time   (start_time),
    .half_per     (half_per)
);

// File: tb/timepin_sched_tb.sv
module timepin_sched_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] tnow;
    logic        ld_en = 1'b0;
    logic [63:0] ld_val = '0;
    logic        mode_capture = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [63:0] cfg_wdata = '0;
    logic        cmd_start = 1'b0;
    logic        cmd_stop = 1'b0;
    logic        pin_in = 1'b0;
    logic        pin_out;
    logic        pin_oe;
    logic [63:0] cap_time;

    int n_checks = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst)        tnow <= '0;
        else if (ld_en) tnow <= ld_val;
        else            tnow <= tnow + 64'd1;
    end

    timepin_sched u_dut (
        .clk          (clk),
        .rst          (rst),
        .time_now     (tnow),
        .mode_capture (mode_capture),
        .cfg_wr       (cfg_wr),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cmd_start    (cmd_start),
        .cmd_stop     (cmd_stop),
        .pin_in       (pin_in),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe),
        .cap_time     (cap_time)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic exp_pin(input logic [63:0] t, input logic [63:0] s, input logic [63:0] h);
        logic [63:0] n;
        if (t <= s) return 1'b0;
        n = (t - s - 64'd1) / h + 64'd1;
        return n[0];
    endfunction

    task automatic cfg_write(input logic a, input logic [63:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_start();
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic pulse_stop();
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
    endtask

    // Writes half-period word and start = tnow + off; then pulses start. Returns start time.
    task automatic arm(input logic [63:0] hw, input logic [63:0] off, output logic [63:0] s);
        logic [63:0] tw;
        cfg_write(1'b1, hw);
        tw = tnow;
        s = tw + off;
        cfg_write(1'b0, s);
        pulse_start();
    endtask

    task automatic watch_wave(input string req, input logic [63:0] s, input logic [63:0] h, input int cyc);
        for (int i = 0; i < cyc; i++) begin
            chk(pin_out == exp_pin(tnow, s, h), req, {63'd0, pin_out}, {63'd0, exp_pin(tnow, s, h)});
            @(negedge clk);
        end
    endtask

    task automatic watch_low(input string req, input int cyc);
        for (int i = 0; i < cyc; i++) begin
            chk(pin_out == 1'b0, req, {63'd0, pin_out}, 64'd0);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(pin_out == 1'b0, "R1 pin_out", {63'd0, pin_out}, 64'd0);
        chk(pin_oe == 1'b1, "R1 pin_oe", {63'd0, pin_oe}, 64'd1);
        chk(cap_time == 64'd0, "R1 cap_time", cap_time, 64'd0);
    endtask

    task automatic t_late_start();
        logic [63:0] s;
        arm(64'd3, 64'd1, s);   // start equals time_now at pulse: dropped
        watch_low("R2 start not in future", 20);
        arm(64'd3, 64'd0, s);   // start already past
        watch_low("R2 start in past", 20);
        arm(64'd0, 64'd5, s);   // zero half-period
        watch_low("R2 zero half-period", 20);
    endtask

    task automatic t_wave(input string req, input logic [63:0] hw, input logic [63:0] h, input logic [63:0] off);
        logic [63:0] s;
        arm(hw, off, s);
        watch_wave(req, s, h, int'(6 * h + off + 8));
        pulse_stop();
    endtask

    task automatic t_wide_time();
        logic [63:0] s;
        ld_en = 1'b1; ld_val = 64'h0000_0001_FFFF_FFF0;
        @(negedge clk);
        ld_en = 1'b0;
        arm(64'd5, 64'd9, s);
        watch_wave("R4 64-bit compare across carry", s, 64'd5, 50);
        pulse_stop();
    endtask

    task automatic t_stop();
        logic [63:0] s;
        arm(64'd2, 64'd3, s);
        watch_wave("R4 before stop", s, 64'd2, 9);
        pulse_stop();
        watch_low("R5 low after stop", 15);
        cfg_write(1'b0, tnow + 64'd4);
        cmd_start = 1'b1; cmd_stop = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0; cmd_stop = 1'b0;
        watch_low("R5 stop wins over start", 20);
    endtask

    task automatic t_rearm();
        logic [63:0] s;
        arm(64'd4, 64'd2, s);
        watch_wave("R4 first schedule", s, 64'd4, 7);
        arm(64'd3, 64'd6, s);
        watch_wave("R10 rearm", s, 64'd3, 30);
        pulse_stop();
    endtask

    task automatic t_mode();
        logic [63:0] s;
        arm(64'd2, 64'd2, s);
        watch_wave("R4 before mode switch", s, 64'd2, 6);
        mode_capture = 1'b1;
        #1;
        chk(pin_oe == 1'b0, "R6 pin_oe in capture mode", {63'd0, pin_oe}, 64'd0);
        @(negedge clk);
        watch_low("R6 pin low in capture mode", 5);
        cfg_write(1'b0, tnow + 64'd3);
        pulse_start();
        watch_low("R6 start ignored in capture mode", 10);
        mode_capture = 1'b0;
        #1;
        chk(pin_oe == 1'b1, "R6 pin_oe in output mode", {63'd0, pin_oe}, 64'd1);
        @(negedge clk);
        watch_low("R6 no schedule after return", 10);
    endtask

    task automatic edge_and_check(input logic lvl, input string req);
        logic [63:0] t;
        t = tnow;
        pin_in = lvl;
        repeat (3) @(negedge clk);
        chk(cap_time == t + 64'd2, req, cap_time, t + 64'd2);
    endtask

    task automatic t_capture();
        logic [63:0] t;
        logic [63:0] held;
        mode_capture = 1'b1;
        repeat (2) @(negedge clk);
        edge_and_check(1'b1, "R7 rising edge");
        repeat (5) @(negedge clk);
        edge_and_check(1'b0, "R7 falling edge");
        held = cap_time;
        repeat (10) @(negedge clk);
        chk(cap_time == held, "R8 hold without edge", cap_time, held);
        t = tnow;
        pin_in = 1'b1;
        @(negedge clk);
        pin_in = 1'b0;
        repeat (4) @(negedge clk);
        chk(cap_time == t + 64'd3, "R8 overwrite by later edge", cap_time, t + 64'd3);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_cap_ignored();
        logic [63:0] held;
        mode_capture = 1'b0;
        repeat (3) @(negedge clk);
        held = cap_time;
        pin_in = 1'b1;
        repeat (6) @(negedge clk);
        pin_in = 1'b0;
        repeat (6) @(negedge clk);
        chk(cap_time == held, "R9 edges ignored in output mode", cap_time, held);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_late_start();
        t_wave("R3 R4 half-period 1", 64'd1, 64'd1, 64'd2);
        t_wave("R3 R4 half-period 3", 64'd3, 64'd3, 64'd5);
        t_wave("R4 half-period 5", 64'd5, 64'd5, 64'd12);
        t_wave("R11 upper bits dropped", 64'hABCD_0000_0000_0004, 64'd4, 64'd3);
        t_wide_time();
        t_stop();
        t_rearm();
        t_mode();
        t_capture();
        t_cap_ignored();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule